// File: doc/BRIEF.md
# Packed Logical Left Shifter

This block shifts a 64-bit packed operand to the left, treating it as four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane moves by the same count, and zeros fill the bit positions that the shift empties. The opcode byte selects both the lane width and where the count comes from. A count can come from a full 64-bit count operand or from an 8-bit immediate.

The block sits in a multimedia execution pipe. It accepts one operation per cycle and returns the result one clock edge later. An immediate form must carry an addressing byte in register mode with the sub-operation field equal to 110. If it does not, or if the opcode is not a shift that this block handles, the block flags the operation as illegal and returns zero.

Top module: `packed_lshift`

## Requirements
- R1: Opcode 0xF1 shifts each of the four 16-bit lanes of `src_a` left by the count in `src_cnt`, filling vacated bits with zero.
- R2: Opcode 0xF2 shifts each of the two 32-bit lanes of `src_a` left by the count in `src_cnt`, filling vacated bits with zero.
- R3: Opcode 0xF3 shifts the whole 64-bit `src_a` left by the count in `src_cnt`, filling vacated bits with zero.
- R4: Opcodes 0x71, 0x72 and 0x73 perform the 16-, 32- and 64-bit lane shifts with `imm8`, zero-extended, as the count, and `src_cnt` is ignored.
- R5: The count is taken as an unsigned value over its full width. Any count greater than or equal to the lane width, including a count with only high bits set, clears every lane to zero.
- R6: An immediate-form opcode whose `modrm` does not have bits [7:6] = 11 and bits [5:3] = 110 drives `illegal` to 1 and `result` to zero. Register-form opcodes ignore `modrm`.
- R7: Any opcode other than the six listed drives `illegal` to 1 and `result` to zero. A legal operation drives `illegal` to 0.
- R8: `out_valid` equals `in_valid` from one cycle earlier. While `in_valid` is low, `result` and `illegal` keep their values.
- R9: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Second opcode byte selecting lane width and count source |
| modrm | input | 8 | Addressing byte; checked for immediate forms only |
| src_a | input | 64 | Packed operand to shift |
| src_cnt | input | 64 | Count operand for register-count forms |
| imm8 | input | 8 | Immediate count for immediate forms |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Shifted operand |
| illegal | output | 1 | Operation was not a legal shift |

## Verification
The assertions check the cycle rules on every cycle:
- the one-cycle valid delay;
- result and flag holding while no operation arrives;
- zero results for illegal operations;
- zero results for over-range counts, whether from the count operand or the immediate;
- the illegal flag for unknown opcodes.

The actual lane arithmetic shows only in the bench's scenarios. These compare each result against an independent per-lane model: random operands and counts, counts at exactly the lane width minus one and the lane width, counts with only high bits set, and malformed addressing bytes.

// File: rtl/packed_lshift.sv
module packed_lshift #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    opcode,
  input  logic [7:0]    modrm,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_cnt,
  input  logic [7:0]    imm8,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          illegal
);
  localparam int NW = DW / 16;
  localparam int ND = DW / 32;

  logic          is_reg, is_imm, imm_ok, bad;
  logic [DW-1:0] cnt;
  logic [DW-1:0] res_w, res_d, res_q, res_sel;

  assign is_reg = (opcode == 8'hF1) || (opcode == 8'hF2) || (opcode == 8'hF3);
  assign is_imm = (opcode == 8'h71) || (opcode == 8'h72) || (opcode == 8'h73);
  assign imm_ok = (modrm[7:6] == 2'b11) && (modrm[5:3] == 3'b110);
  assign bad    = !(is_reg || (is_imm && imm_ok));
  assign cnt    = is_imm ? {{(DW-8){1'b0}}, imm8} : src_cnt;

  genvar i;
  generate
    for (i = 0; i < NW; i++) begin : g_word
      assign res_w[16*i +: 16] = (|cnt[DW-1:4]) ? 16'd0 : (src_a[16*i +: 16] << cnt[3:0]);
    end
    for (i = 0; i < ND; i++) begin : g_dword
      assign res_d[32*i +: 32] = (|cnt[DW-1:5]) ? 32'd0 : (src_a[32*i +: 32] << cnt[4:0]);
    end
  endgenerate

  assign res_q = (|cnt[DW-1:6]) ? '0 : (src_a << cnt[5:0]);

  always_comb begin
    case (opcode[1:0])
      2'b01:   res_sel = res_w;
      2'b10:   res_sel = res_d;
      default: res_sel = res_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      illegal   <= bad;
      result    <= bad ? '0 : res_sel;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

module packed_lshift_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    opcode,
  input logic [7:0]    modrm,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_cnt,
  input logic [7:0]    imm8,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          illegal
);
  logic known_op;
  assign known_op = (opcode == 8'hF1) || (opcode == 8'hF2) || (opcode == 8'hF3) ||
                    (opcode == 8'h71) || (opcode == 8'h72) || (opcode == 8'h73);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));
  a_r7_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |=> illegal);
  a_r5_word_overrange: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'hF1 && src_cnt >= 16) |=> (result == '0));
  a_r4_imm_overrange: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h73 && modrm == 8'hF0 && imm8 >= 8'd64) |=> (result == '0 && !illegal));
endmodule

bind packed_lshift packed_lshift_chk #(.DW(DW)) u_chk (.*);

// File: tb/packed_lshift_tb.sv
module packed_lshift_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  modrm = 8'h00;
  logic [63:0] src_a = '0;
  logic [63:0] src_cnt = '0;
  logic [7:0]  imm8 = 8'h00;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_lshift u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .modrm(modrm),
    .src_a(src_a), .src_cnt(src_cnt), .imm8(imm8),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [63:0] lane_shift(input logic [63:0] a, input logic [63:0] c, input int lw);
    logic [63:0] mask, lane, acc;
    mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    acc = '0;
    for (int i = 0; i < 64 / lw; i++) begin
      lane = (a >> (i * lw)) & mask;
      if (c >= 64'(lw)) lane = '0;
      else lane = (lane << c[5:0]) & mask;
      acc = acc | (lane << (i * lw));
    end
    return acc;
  endfunction

  function automatic logic [64:0] model(input logic [7:0] op, input logic [7:0] mr,
                                        input logic [63:0] a, input logic [63:0] c, input logic [7:0] im);
    int lw;
    logic [63:0] cc;
    case (op)
      8'hF1: begin lw = 16; cc = c; end
      8'hF2: begin lw = 32; cc = c; end
      8'hF3: begin lw = 64; cc = c; end
      8'h71: begin lw = 16; cc = {56'd0, im}; end
      8'h72: begin lw = 32; cc = {56'd0, im}; end
      8'h73: begin lw = 64; cc = {56'd0, im}; end
      default: return {1'b1, 64'd0};
    endcase
    if (op[7:4] == 4'h7 && !(mr[7:6] == 2'b11 && mr[5:3] == 3'b110)) return {1'b1, 64'd0};
    return {1'b0, lane_shift(a, cc, lw)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] op, input logic [7:0] mr,
                        input logic [63:0] a, input logic [63:0] c, input logic [7:0] im);
    logic [64:0] e;
    e = model(op, mr, a, c, im);
    opcode = op; modrm = mr; src_a = a; src_cnt = c; imm8 = im; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " flag"}, {63'd0, illegal}, {63'd0, e[64]});
    check({tag, " result"}, result, e[63:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [7:0] ops [6];
    void'($urandom(32'd2024));
    ops = '{8'hF1, 8'hF2, 8'hF3, 8'h71, 8'h72, 8'h73};
    repeat (3) @(negedge clk);
    check("R9 valid", {63'd0, out_valid}, 64'd0);
    check("R9 flag", {63'd0, illegal}, 64'd0);
    check("R9 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 word by 4", 8'hF1, 8'h00, 64'h8001_7FFF_1234_FFFF, 64'd4, 8'd0);
    run_op("R1 word by 15", 8'hF1, 8'h00, 64'h0001_0003_FFFF_8000, 64'd15, 8'd0);
    run_op("R2 dword by 31", 8'hF2, 8'h00, 64'h0000_0001_FFFF_FFFF, 64'd31, 8'd0);
    run_op("R3 qword by 63", 8'hF3, 8'h00, 64'h0000_0000_0000_0003, 64'd63, 8'd0);
    run_op("R3 qword by 0", 8'hF3, 8'h00, 64'hDEAD_BEEF_0123_4567, 64'd0, 8'd0);
    run_op("R5 word at 16", 8'hF1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 8'd0);
    run_op("R5 dword at 32", 8'hF2, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32, 8'd0);
    run_op("R5 qword at 64", 8'hF3, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 8'd0);
    run_op("R5 high count bit", 8'hF3, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_0000_0001, 8'd0);
    run_op("R4 imm word", 8'h71, 8'hF0, 64'h1111_2222_3333_4444, 64'd0, 8'd3);
    run_op("R4 imm ignores cnt", 8'h72, 8'hF5, 64'h8000_0001_4000_0001, 64'd40, 8'd1);
    run_op("R4 imm qword 255", 8'h73, 8'hF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd255);
    run_op("R6 bad reg field", 8'h71, 8'hE8, 64'hFFFF, 64'd0, 8'd1);
    run_op("R6 memory mode", 8'h73, 8'h30, 64'hFFFF, 64'd0, 8'd1);
    run_op("R6 reg form ignores modrm", 8'hF2, 8'h05, 64'h0000_00FF_0000_00FF, 64'd8, 8'd0);
    run_op("R7 unknown op", 8'hF4, 8'hF0, 64'hFFFF, 64'd1, 8'd1);
    run_op("R7 right shift op", 8'hD1, 8'h00, 64'hFFFF, 64'd1, 8'd1);

    run_op("R8 setup", 8'hF1, 8'h00, 64'h0F0F_0F0F_0F0F_0F0F, 64'd2, 8'd0);
    held = result;
    opcode = 8'hF4; src_a = '1; src_cnt = 64'd1;
    @(posedge clk); @(negedge clk);
    check("R8 idle valid", {63'd0, out_valid}, 64'd0);
    check("R8 idle result hold", result, held);
    check("R8 idle flag hold", {63'd0, illegal}, 64'd0);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] op, mr, im;
      logic [63:0] a, c;
      op = ops[$urandom_range(0, 5)];
      if ($urandom_range(0, 19) == 0) op = 8'($urandom);
      mr = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hF0 | 8'($urandom_range(0, 7));
      a = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: c = {$urandom, $urandom};
        1: c = 64'($urandom_range(0, 70));
        default: c = 64'($urandom_range(0, 33));
      endcase
      im = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 70)) : 8'($urandom);
      run_op("R1/R2/R3/R4 random", op, mr, a, c, im);
      if ($urandom_range(0, 4) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule